// File: doc/BRIEF.md
# Reflection Echo Polarity and Distance Analyzer

The block scans a stored reflectometry record of 1024 unsigned 8-bit samples held in an external sample buffer. It reads the buffer in one pass through a synchronous read port. It looks for two events:

- the launched pulse, which is the first excursion beyond a threshold band around a baseline level;
- the first reflection after the pulse has settled back inside that band.

The sample delay between the two events is converted to a one-way distance in metres. The conversion uses a fixed-point factor built from the sample period and a propagation velocity. The result is then rounded to a selectable resolution step.

The polarity of the reflection decides the fault class. A reflection above the baseline means an open circuit or poor contact. A reflection below it means a short circuit or low-resistance fault. Distances outside 2 m to 1000 m are reported as out of range. A record without a usable launch or reflection is reported as no fault. In every case the valid flag is raised when the scan completes.

The control state machine has six states:

| State | Role | Leaves on |
|---|---|---|
| IDLE | after reset | `start_i` to SEEK_LAUNCH |
| SEEK_LAUNCH | looks for the launch excursion | excursion to SETTLE; last sample with none seen to REPORT |
| SETTLE | waits for the launch to return inside the band | an inside sample to SEEK_ECHO; last sample to REPORT |
| SEEK_ECHO | looks for the reflection | excursion to MEASURE; last sample with none seen to REPORT |
| MEASURE | waits for the distance scaler | scaler done to REPORT |
| REPORT | holds the result with valid high | `start_i` to SEEK_LAUNCH |

The distance scaler has its own two states:

| State | Role | Leaves on |
|---|---|---|
| SC_IDLE | waits for a request | start: loads the product and moves to SC_DIVIDE |
| SC_DIVIDE | subtracts one resolution step per cycle | remainder below one step, or the count passes the upper limit: back to SC_IDLE with done |

Top module: `echo_analyzer`

## Requirements
- R1: A sample is an excursion only when its signed deviation (sample minus baseline, both 8-bit unsigned) is strictly greater than the threshold or strictly less than minus the threshold. The launch pulse is the first excursion in the record, scanning from address 0 upward.
- R2: The reflection is the first excursion after at least one non-excursion sample has followed the launch. An excursion at the final address 1023 still counts as a reflection.
- R3: A reflection with positive deviation reports fault code 2'b01 (open or poor contact).
- R4: A reflection with negative deviation reports fault code 2'b10 (short or low resistance).
- R5: With delay D = reflection index minus launch index, period P and velocity V, the raw distance is D*P*V/2048 metres. The reported distance is that value rounded half-up to a multiple of the step. The step is 2 m when `coarse_i`=0 and 10 m when `coarse_i`=1.
- R6: A rounded distance below 2 m or above 1000 m reports fault code 2'b11 (out of range), with distance 0.
- R7: If the record ends with no launch, with the launch never settling, or with no reflection, the block reports fault code 2'b00 with distance 0 and still raises `valid_o`.
- R8: After reset `valid_o`, `fault_o` and `dist_o` are 0. Once raised, `valid_o` and the result stay unchanged until the next `start_i`, which clears `valid_o` on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a scan (accepted in IDLE or REPORT) |
| base_i | input | 8 | Baseline level |
| thresh_i | input | 8 | Detection threshold (magnitude) |
| period_i | input | 8 | Sample period in ns |
| vel_i | input | 12 | Propagation velocity in units of 1/1024 m/ns |
| coarse_i | input | 1 | Resolution select: 0 gives 2 m, 1 gives 10 m |
| rd_addr_o | output | 10 | Sample buffer read address |
| rd_data_i | input | 8 | Sample buffer data, one cycle after the address |
| valid_o | output | 1 | Result valid |
| fault_o | output | 2 | Fault class code |
| dist_o | output | 10 | One-way distance in metres |

## Verification
The bench builds the block with its default parameters: a 1024-entry record, 8-bit samples, a 12-bit velocity and an 11-bit binary scale. With a period of 1 ns and a velocity of 2048, one sample of delay equals exactly one metre, so both range limits and the half-step rounding points can be reached with chosen integer delays. Other period and velocity pairs exercise the multiplier path at realistic scale. The full record depth also places a reflection on the very last address and lets a launch stay out to the end of the record.

// File: rtl/echo_pkg.sv
package echo_pkg;

    typedef enum logic [1:0] {
        FAULT_NONE  = 2'b00,
        FAULT_OPEN  = 2'b01,
        FAULT_SHORT = 2'b10,
        FAULT_RANGE = 2'b11
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEEK_LAUNCH,
        ST_SETTLE,
        ST_SEEK_ECHO,
        ST_MEASURE,
        ST_REPORT
    } scan_state_e;

    typedef enum logic {
        SC_IDLE,
        SC_DIVIDE
    } scale_state_e;

endpackage

// File: rtl/echo_sample_fetch.sv
module echo_sample_fetch #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              halt,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              smp_valid,
    output logic [ADDR_W-1:0] smp_idx,
    output logic              smp_last
);
    localparam logic [ADDR_W-1:0] LAST_IDX = '1;

    logic running;

    // Streams addresses 0..LAST_IDX; data returns one cycle later.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            running   <= 1'b0;
            rd_addr   <= '0;
            smp_valid <= 1'b0;
            smp_idx   <= '0;
        end else if (go) begin
            running   <= 1'b1;
            rd_addr   <= '0;
            smp_valid <= 1'b0;
        end else begin
            smp_valid <= running && !halt;
            smp_idx   <= rd_addr;
            if (halt) begin
                running <= 1'b0;
            end else if (running) begin
                if (rd_addr == LAST_IDX) running <= 1'b0;
                else                     rd_addr <= rd_addr + 1'b1;
            end
        end
    end

    assign smp_last = (smp_idx == LAST_IDX);

endmodule

// File: rtl/echo_level_cmp.sv
module echo_level_cmp #(
    parameter int SAMPLE_W = 8
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [SAMPLE_W-1:0] baseline,
    input  logic [SAMPLE_W-1:0] threshold,
    output logic                above,
    output logic                below
);
    logic signed [SAMPLE_W:0] dev;
    logic signed [SAMPLE_W:0] thr_s;

    always_comb begin
        dev   = $signed({1'b0, sample}) - $signed({1'b0, baseline});
        thr_s = $signed({1'b0, threshold});
        above = (dev > thr_s);
        below = (dev < -thr_s);
    end

endmodule

// File: rtl/echo_dist_scaler.sv
module echo_dist_scaler
    import echo_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int PERIOD_W    = 8,
    parameter int VEL_W       = 12,
    parameter int FRAC_W      = 11,
    parameter int DIST_W      = 10,
    parameter int MIN_M       = 2,
    parameter int MAX_M       = 1000,
    parameter int FINE_STEP   = 2,
    parameter int COARSE_STEP = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   delay,
    input  logic [PERIOD_W-1:0] period,
    input  logic [VEL_W-1:0]    vel,
    input  logic                coarse,
    output logic                done,
    output logic                in_range,
    output logic [DIST_W-1:0]   dist_m
);
    localparam int ACC_W = ADDR_W + PERIOD_W + VEL_W + 1;
    localparam int RES_W = DIST_W + 1;
    localparam logic [ACC_W-1:0] FINE_Q   = ACC_W'(FINE_STEP) << FRAC_W;
    localparam logic [ACC_W-1:0] COARSE_Q = ACC_W'(COARSE_STEP) << FRAC_W;
    localparam logic [RES_W-1:0] RES_MAX  = RES_W'(MAX_M);
    localparam logic [RES_W-1:0] RES_MIN  = RES_W'(MIN_M);

    scale_state_e     state_q, state_d;
    logic [ACC_W-1:0] acc_q;
    logic [RES_W-1:0] res_q;
    logic             coarse_q;
    logic [ACC_W-1:0] step_q;
    logic [RES_W-1:0] step_m;
    logic [ACC_W-1:0] half_in;
    logic             more;

    always_comb begin
        step_q  = coarse_q ? COARSE_Q : FINE_Q;
        step_m  = coarse_q ? RES_W'(COARSE_STEP) : RES_W'(FINE_STEP);
        half_in = (coarse ? COARSE_Q : FINE_Q) >> 1;
        more    = (acc_q >= step_q) && (res_q <= RES_MAX);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_IDLE:   if (start) state_d = SC_DIVIDE;
            SC_DIVIDE: if (!more) state_d = SC_IDLE;
            default:   state_d = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SC_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            res_q    <= '0;
            coarse_q <= 1'b0;
            done     <= 1'b0;
            in_range <= 1'b0;
            dist_m   <= '0;
        end else begin
            done <= 1'b0;
            if (state_q == SC_IDLE && start) begin
                acc_q    <= ACC_W'(delay) * ACC_W'(period) * ACC_W'(vel) + half_in;
                res_q    <= '0;
                coarse_q <= coarse;
            end else if (state_q == SC_DIVIDE) begin
                if (more) begin
                    acc_q <= acc_q - step_q;
                    res_q <= res_q + step_m;
                end else begin
                    done     <= 1'b1;
                    in_range <= (res_q >= RES_MIN) && (res_q <= RES_MAX);
                    dist_m   <= ((res_q >= RES_MIN) && (res_q <= RES_MAX))
                                ? res_q[DIST_W-1:0] : '0;
                end
            end
        end
    end

endmodule

// File: rtl/echo_analyzer.sv
module echo_analyzer
    import echo_pkg::*;
#(
    parameter int SAMPLE_W    = 8,
    parameter int ADDR_W      = 10,
    parameter int PERIOD_W    = 8,
    parameter int VEL_W       = 12,
    parameter int FRAC_W      = 11,
    parameter int DIST_W      = 10,
    parameter int MIN_M       = 2,
    parameter int MAX_M       = 1000,
    parameter int FINE_STEP   = 2,
    parameter int COARSE_STEP = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [SAMPLE_W-1:0] base_i,
    input  logic [SAMPLE_W-1:0] thresh_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic [VEL_W-1:0]    vel_i,
    input  logic                coarse_i,
    output logic [ADDR_W-1:0]   rd_addr_o,
    input  logic [SAMPLE_W-1:0] rd_data_i,
    output logic                valid_o,
    output logic [1:0]          fault_o,
    output logic [DIST_W-1:0]   dist_o
);
    scan_state_e       state_q, state_d;
    logic              smp_valid, smp_last;
    logic [ADDR_W-1:0] smp_idx;
    logic              above, below, excursion;
    logic [ADDR_W-1:0] launch_idx_q;
    logic              positive_q;
    logic              go, sc_start, sc_done, sc_in_range;
    logic [DIST_W-1:0] sc_dist;
    logic [ADDR_W-1:0] delay;

    assign go        = start_i && (state_q == ST_IDLE || state_q == ST_REPORT);
    assign excursion = above || below;
    assign sc_start  = (state_q == ST_SEEK_ECHO) && smp_valid && excursion;
    assign delay     = smp_idx - launch_idx_q;

    echo_sample_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .halt      (sc_start),
        .rd_addr   (rd_addr_o),
        .smp_valid (smp_valid),
        .smp_idx   (smp_idx),
        .smp_last  (smp_last)
    );

    echo_level_cmp #(.SAMPLE_W(SAMPLE_W)) u_cmp (
        .sample    (rd_data_i),
        .baseline  (base_i),
        .threshold (thresh_i),
        .above     (above),
        .below     (below)
    );

    echo_dist_scaler #(
        .ADDR_W(ADDR_W), .PERIOD_W(PERIOD_W), .VEL_W(VEL_W), .FRAC_W(FRAC_W),
        .DIST_W(DIST_W), .MIN_M(MIN_M), .MAX_M(MAX_M),
        .FINE_STEP(FINE_STEP), .COARSE_STEP(COARSE_STEP)
    ) u_scale (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (sc_start),
        .delay    (delay),
        .period   (period_i),
        .vel      (vel_i),
        .coarse   (coarse_i),
        .done     (sc_done),
        .in_range (sc_in_range),
        .dist_m   (sc_dist)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_SEEK_LAUNCH;
            ST_SEEK_LAUNCH:
                if (smp_valid) begin
                    if (excursion && !smp_last) state_d = ST_SETTLE;
                    else if (smp_last)          state_d = ST_REPORT;
                end
            ST_SETTLE:
                if (smp_valid) begin
                    if (smp_last)        state_d = ST_REPORT;
                    else if (!excursion) state_d = ST_SEEK_ECHO;
                end
            ST_SEEK_ECHO:
                if (smp_valid) begin
                    if (excursion)     state_d = ST_MEASURE;
                    else if (smp_last) state_d = ST_REPORT;
                end
            ST_MEASURE: if (sc_done) state_d = ST_REPORT;
            ST_REPORT:  if (start_i) state_d = ST_SEEK_LAUNCH;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and captured scan data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            launch_idx_q <= '0;
            positive_q   <= 1'b0;
            valid_o      <= 1'b0;
            fault_o      <= FAULT_NONE;
            dist_o       <= '0;
        end else begin
            if (state_q == ST_SEEK_LAUNCH && smp_valid && excursion)
                launch_idx_q <= smp_idx;
            if (sc_start)
                positive_q <= above;
            valid_o <= (state_d == ST_REPORT);
            if (state_q != ST_REPORT && state_d == ST_REPORT) begin
                if (state_q == ST_MEASURE && sc_in_range) begin
                    fault_o <= positive_q ? FAULT_OPEN : FAULT_SHORT;
                    dist_o  <= sc_dist;
                end else if (state_q == ST_MEASURE) begin
                    fault_o <= FAULT_RANGE;
                    dist_o  <= '0;
                end else begin
                    fault_o <= FAULT_NONE;
                    dist_o  <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/echo_analyzer_chk.sv
module echo_analyzer_chk #(
    parameter int DIST_W = 10,
    parameter int MIN_M  = 2,
    parameter int MAX_M  = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              valid_o,
    input logic [1:0]        fault_o,
    input logic [DIST_W-1:0] dist_o
);
    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !start_i |=> valid_o); // R8
    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !start_i |=> $stable(fault_o) && $stable(dist_o)); // R8
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && start_i |=> !valid_o); // R8
    AST_FAULT_DIST_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && (fault_o == 2'b01 || fault_o == 2'b10)
        |-> (dist_o >= DIST_W'(MIN_M)) && (dist_o <= DIST_W'(MAX_M))); // R5
    AST_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && fault_o == 2'b11 |-> dist_o == '0); // R6
    AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && fault_o == 2'b00 |-> dist_o == '0); // R7
endmodule

bind echo_analyzer echo_analyzer_chk #(
    .DIST_W(DIST_W), .MIN_M(MIN_M), .MAX_M(MAX_M)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .valid_o (valid_o),
    .fault_o (fault_o),
    .dist_o  (dist_o)
);

// File: tb/echo_analyzer_tb.sv
`timescale 1ns/1ps
module echo_analyzer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  base_i = 8'd128;
    logic [7:0]  thresh_i = 8'd20;
    logic [7:0]  period_i = 8'd10;
    logic [11:0] vel_i = 12'd205;
    logic        coarse_i = 1'b0;
    logic [9:0]  rd_addr_o;
    logic [7:0]  rd_data_i;
    logic        valid_o;
    logic [1:0]  fault_o;
    logic [9:0]  dist_o;

    logic [7:0]  mem [0:1023];
    int          nchk = 0;
    int          nfail = 0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) rd_data_i <= mem[rd_addr_o];

    echo_analyzer u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .thresh_i(thresh_i), .period_i(period_i), .vel_i(vel_i),
        .coarse_i(coarse_i), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .valid_o(valid_o), .fault_o(fault_o), .dist_o(dist_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_dist(input int delay, input int per, input int vel, input bit crs);
        longint raw;
        int     step;
        step = crs ? 10 : 2;
        raw  = longint'(delay) * per * vel;
        return int'((raw + step * 1024) / (step * 2048)) * step;
    endfunction

    task automatic fill(input int from, input int to, input int val);
        for (int i = from; i <= to; i++) mem[i] = 8'(val);
    endtask

    task automatic setup(input int per, input int vel, input bit crs);
        fill(0, 1023, 128);
        period_i = 8'(per);
        vel_i    = 12'(vel);
        coarse_i = crs;
    endtask

    task automatic run_scan(input string tag, input int ef, input int ed);
        int waited;
        waited = 0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        check(tag, "valid cleared after start", int'(valid_o), 0);
        while (!valid_o && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        check(tag, "valid", int'(valid_o), 1);
        check(tag, "fault", int'(fault_o), ef);
        check(tag, "dist", int'(dist_o), ed);
    endtask

    // Expected fault/distance for a found reflection, with range rule (R6)
    task automatic run_echo(input string tag, input int pol_code, input int delay);
        int d;
        d = exp_dist(delay, int'(period_i), int'(vel_i), coarse_i);
        if (d < 2 || d > 1000) run_scan(tag, 3, 0);
        else                   run_scan(tag, pol_code, d);
    endtask

    task automatic t_reset;
        check("R8 reset", "valid", int'(valid_o), 0);
        check("R8 reset", "fault", int'(fault_o), 0);
        check("R8 reset", "dist", int'(dist_o), 0);
    endtask

    task automatic t_open;   // R3 positive reflection, R5 fine scale
        setup(10, 205, 1'b0);
        fill(5, 9, 220);
        fill(105, 107, 170);
        run_echo("R3 open", 1, 100);
    endtask

    task automatic t_short;  // R4 negative reflection, R5 coarse scale
        setup(10, 205, 1'b1);
        fill(20, 23, 230);
        mem[320] = 8'd60;
        run_echo("R4 short", 2, 300);
    endtask

    task automatic t_hold;   // R8 result held without start
        repeat (25) @(negedge clk);
        check("R8 hold", "valid", int'(valid_o), 1);
        check("R8 hold", "fault", int'(fault_o), 2);
        check("R8 hold", "dist", int'(dist_o), 300);
    endtask

    task automatic t_thresh; // R1 deviation equal to threshold is not an excursion
        setup(10, 205, 1'b0);
        mem[3]   = 8'd148;
        fill(5, 9, 220);
        mem[200] = 8'd108;
        mem[400] = 8'd149;
        run_echo("R1 threshold", 1, 395);
    endtask

    task automatic t_no_echo;
        setup(10, 205, 1'b0);
        fill(5, 9, 220);
        run_scan("R7 no reflection", 0, 0);
    endtask

    task automatic t_no_launch;
        setup(10, 205, 1'b0);
        run_scan("R7 no launch", 0, 0);
    endtask

    task automatic t_never_settle; // R2 launch never returns inside band
        setup(10, 205, 1'b0);
        fill(10, 1023, 220);
        run_scan("R2 never settles", 0, 0);
    endtask

    task automatic t_last;   // R2 reflection on final address
        setup(5, 205, 1'b0);
        fill(0, 1, 220);
        mem[1023] = 8'd20;
        run_echo("R2 last sample", 2, 1023);
    endtask

    task automatic t_far;    // R6 above upper limit
        setup(20, 205, 1'b0);
        mem[0] = 8'd220;
        mem[900] = 8'd200;
        run_scan("R6 far", 3, 0);
    endtask

    task automatic t_near;   // R6 rounds below lower limit
        setup(2, 205, 1'b0);
        mem[10] = 8'd220;
        mem[12] = 8'd220;
        run_scan("R6 near", 3, 0);
    endtask

    task automatic t_round;  // R5 one metre per sample delay, half rounds up
        setup(1, 2048, 1'b1);
        mem[0] = 8'd220;
        mem[25] = 8'd200;
        run_scan("R5 coarse half-up", 1, 30);
        mem[25] = 8'd128;
        mem[24] = 8'd200;
        run_scan("R5 coarse down", 1, 20);
        coarse_i = 1'b0;
        mem[24] = 8'd128;
        mem[3]  = 8'd60;
        run_scan("R5 fine half-up", 2, 4);
    endtask

    task automatic t_limits; // R6 boundaries of 2 m and 1000 m
        setup(1, 1024, 1'b0);
        mem[0] = 8'd220;
        mem[2] = 8'd200;
        run_scan("R6 lower edge in", 1, 2);
        vel_i = 12'd1023;
        run_scan("R6 lower edge out", 3, 0);
        setup(1, 2048, 1'b0);
        mem[0] = 8'd220;
        mem[1000] = 8'd200;
        run_scan("R6 upper edge in", 1, 1000);
        mem[1000] = 8'd128;
        mem[1001] = 8'd200;
        run_scan("R6 upper edge out", 3, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        fill(0, 1023, 128);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_open();
        t_short();
        t_hold();
        t_thresh();
        t_no_echo();
        t_no_launch();
        t_never_settle();
        t_last();
        t_far();
        t_near();
        t_round();
        t_limits();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule